// File: doc/BRIEF.md
# Ridge Orientation Peak Searcher

This block picks the dominant ridge orientation of one image block. It searches a ring of 16 orientation indices, where the last index and index 0 are neighbours. It does not compute energies itself. For each orientation it needs, it asks an external energy engine over a simple request/response pair: it sends an orientation index and gets back that orientation's total resonance energy. Every energy it receives is stored in a small per-block cache, so no orientation is fetched twice.

A host starts one search per image block. There are three kinds of block:
- **Padding block.** No search runs and the block reports "no direction".
- **First block of a row.** The block scans every orientation in order from 0. It reports the orientation with the largest energy.
- **Any other block.** The search starts at the direction found for the previous block. It fetches that index and its two ring neighbours. It then climbs toward the larger neighbour until it finds a strict local peak whose energy exceeds a programmable threshold. If no orientation qualifies, it reports the index with the highest energy and raises a low-quality flag.

Top module: `orient_peak_search`

## Requirements
- R1: A start with `blk_pad` high produces, on the next cycle, `res_valid` with `res_dir` all ones (value -1), `res_lowq` low, and no energy request.
- R2: A start with `blk_first` high requests every index once, in ascending order from 0 to NORI-1.
  - The result is the index of largest energy; among equal energies the lowest index wins.
  - `res_lowq` is low only if that energy is strictly greater than both ring neighbours' energies and strictly greater than the threshold.
- R3: Any other start uses the previous non-padding result as the seed; the value after reset is 0. The first three fetches are the seed, the seed minus one and the seed plus one (on the ring).
- R4: A centre index is accepted when its energy is strictly greater than both ring neighbours and strictly greater than the threshold. An energy equal to the threshold is rejected.
- R5: After the first rejected centre, the search moves one index toward the neighbour with the larger energy; on a tie it moves up. It keeps that direction for every later step.
- R6: Index arithmetic wraps: NORI-1 plus one is 0, and 0 minus one is NORI-1.
- R7: Within one block, no orientation index is requested more than once.
- R8: If NORI centres are rejected in a seeded search, the result is the index of largest energy with `res_lowq` high.
- R9: The threshold resets to 27,000,000. A cycle with `th_we` high loads `th_wdata` into it.
- R10: `req_valid` and `req_idx` hold steady until a cycle with `rsp_valid` high; `rsp_energy` is taken in that cycle.
- R11: `res_valid` is a one-cycle pulse, and `busy` is low in the cycle the result appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_start | input | 1 | Start a block search (sampled while idle) |
| blk_first | input | 1 | Block is first in its row: full scan |
| blk_pad | input | 1 | Block lies in padding: no direction |
| th_we | input | 1 | Load threshold |
| th_wdata | input | EW | New threshold value |
| req_valid | output | 1 | Energy request pending |
| req_idx | output | IW | Orientation index requested |
| rsp_valid | input | 1 | Energy response; completes the request |
| rsp_energy | input | EW | Total energy for `req_idx` |
| busy | output | 1 | Search in progress |
| res_valid | output | 1 | Result pulse |
| res_dir | output | IW+1 | Signed orientation, -1 for padding |
| res_lowq | output | 1 | No qualifying peak was found |

## Verification
The hardest situation to reach is a seeded search that passes a local peak lying below the threshold. It must keep climbing in its stored direction, wrap across index 0, and reach a stronger peak without fetching any energy twice.

The stimulus table chains blocks so that each result seeds the next. This places the seed exactly on a weak peak, on the antipode of a strong peak (a neighbour tie), and just beside the wrap point. Directed cases follow:
- a peak one unit above the default threshold and one exactly equal to it;
- a lowered threshold that makes the ring's highest index qualify.

// File: rtl/orient_pkg.sv
package orient_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHK,
    ST_WAIT,
    ST_EVAL
  } srch_state_t;

  // Step forward on a ring of n positions.
  function automatic int ring_up(int i, int n);
    return (i == n - 1) ? 0 : i + 1;
  endfunction

  // Step backward on a ring of n positions.
  function automatic int ring_dn(int i, int n);
    return (i == 0) ? n - 1 : i - 1;
  endfunction

endpackage

// File: rtl/orient_energy_store.sv
module orient_energy_store #(
  parameter int NORI = 16,
  parameter int EW   = 32,
  parameter int NRD  = 3,
  localparam int IW  = $clog2(NORI)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     wr_en,
  input  logic [IW-1:0]            wr_idx,
  input  logic [EW-1:0]            wr_data,
  input  logic [NRD-1:0][IW-1:0]   rd_idx,
  output logic [NRD-1:0][EW-1:0]   rd_data,
  output logic [NRD-1:0]           rd_hit
);

  logic [EW-1:0]   mem [NORI];
  logic [NORI-1:0] vld;

  // Data array has no reset so it maps to distributed memory.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  vld <= '0;
    else if (wr_en)  vld[wr_idx] <= 1'b1;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = mem[rd_idx[g]];
    assign rd_hit[g]  = vld[rd_idx[g]];
  end

endmodule

// File: rtl/orient_best_track.sv
module orient_best_track #(
  parameter int IW = 4,
  parameter int EW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          upd,
  input  logic [IW-1:0] idx,
  input  logic [EW-1:0] energy,
  output logic [IW-1:0] best_idx,
  output logic [EW-1:0] best_e
);

  // Strict compare: the earliest arrival keeps a tie.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      best_idx <= '0;
      best_e   <= '0;
    end else if (upd && energy > best_e) begin
      best_idx <= idx;
      best_e   <= energy;
    end
  end

endmodule

// File: rtl/orient_peak_test.sv
module orient_peak_test #(
  parameter int EW = 32
) (
  input  logic [EW-1:0] e_ctr,
  input  logic [EW-1:0] e_lo,
  input  logic [EW-1:0] e_hi,
  input  logic [EW-1:0] thresh,
  output logic          pass,
  output logic          up_pref
);

  assign pass    = (e_ctr > e_lo) && (e_ctr > e_hi) && (e_ctr > thresh);
  assign up_pref = !(e_lo > e_hi);

endmodule

// File: rtl/orient_peak_search.sv
module orient_peak_search #(
  parameter int          NORI     = 16,
  parameter int          EW       = 32,
  parameter int unsigned TH_RESET = 27_000_000,
  localparam int         IW       = $clog2(NORI)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 blk_start,
  input  logic                 blk_first,
  input  logic                 blk_pad,
  input  logic                 th_we,
  input  logic [EW-1:0]        th_wdata,
  output logic                 req_valid,
  output logic [IW-1:0]        req_idx,
  input  logic                 rsp_valid,
  input  logic [EW-1:0]        rsp_energy,
  output logic                 busy,
  output logic                 res_valid,
  output logic signed [IW:0]   res_dir,
  output logic                 res_lowq
);
  import orient_pkg::*;

  localparam logic [IW-1:0] LAST = IW'(NORI - 1);

  srch_state_t st;
  logic              scan, dir_up, go_up;
  logic [IW-1:0]     cur, step_cnt, prev_dir, rq_idx;
  logic [IW-1:0]     ctr, lft, rgt, best_idx, pick;
  logic [EW-1:0]     th_q, best_e;
  logic [2:0][IW-1:0] rd_idx;
  logic [2:0][EW-1:0] rd_data;
  logic [2:0]        rd_hit;
  logic              clr, wr_en, pass, up_pref;

  // In scan mode the centre under test is the running maximum.
  assign ctr    = scan ? best_idx : cur;
  assign lft    = IW'(ring_dn(int'(ctr), NORI));
  assign rgt    = IW'(ring_up(int'(ctr), NORI));
  assign rd_idx = {rgt, lft, ctr};

  assign clr       = (st == ST_IDLE) && blk_start;
  assign wr_en     = (st == ST_WAIT) && rsp_valid;
  assign req_valid = (st == ST_WAIT);
  assign req_idx   = rq_idx;
  assign busy      = (st != ST_IDLE);
  assign go_up     = (step_cnt == '0) ? up_pref : dir_up;
  assign pick      = pass ? ctr : best_idx;

  orient_energy_store #(.NORI(NORI), .EW(EW), .NRD(3)) i_store (
    .clk(clk), .rst(rst), .clr(clr),
    .wr_en(wr_en), .wr_idx(rq_idx), .wr_data(rsp_energy),
    .rd_idx(rd_idx), .rd_data(rd_data), .rd_hit(rd_hit)
  );

  orient_best_track #(.IW(IW), .EW(EW)) i_best (
    .clk(clk), .rst(rst), .clr(clr), .upd(wr_en),
    .idx(rq_idx), .energy(rsp_energy),
    .best_idx(best_idx), .best_e(best_e)
  );

  orient_peak_test #(.EW(EW)) i_test (
    .e_ctr(rd_data[0]), .e_lo(rd_data[1]), .e_hi(rd_data[2]),
    .thresh(th_q), .pass(pass), .up_pref(up_pref)
  );

  always_ff @(posedge clk) begin
    if (rst)        th_q <= EW'(TH_RESET);
    else if (th_we) th_q <= th_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      scan      <= 1'b0;
      dir_up    <= 1'b1;
      cur       <= '0;
      step_cnt  <= '0;
      prev_dir  <= '0;
      rq_idx    <= '0;
      res_valid <= 1'b0;
      res_dir   <= '0;
      res_lowq  <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (blk_start) begin
            if (blk_pad) begin
              res_valid <= 1'b1;
              res_dir   <= '1;
              res_lowq  <= 1'b0;
            end else if (blk_first) begin
              scan   <= 1'b1;
              rq_idx <= '0;
              st     <= ST_WAIT;
            end else begin
              scan     <= 1'b0;
              cur      <= prev_dir;
              step_cnt <= '0;
              st       <= ST_CHK;
            end
          end
        end
        ST_CHK: begin
          if (!rd_hit[0]) begin
            rq_idx <= ctr;
            st     <= ST_WAIT;
          end else if (!rd_hit[1]) begin
            rq_idx <= lft;
            st     <= ST_WAIT;
          end else if (!rd_hit[2]) begin
            rq_idx <= rgt;
            st     <= ST_WAIT;
          end else begin
            st <= ST_EVAL;
          end
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            if (!scan)                st     <= ST_CHK;
            else if (rq_idx == LAST)  st     <= ST_EVAL;
            else                      rq_idx <= rq_idx + 1'b1;
          end
        end
        ST_EVAL: begin
          if (pass || scan || step_cnt == LAST) begin
            res_valid <= 1'b1;
            res_dir   <= signed'({1'b0, pick});
            res_lowq  <= !pass;
            prev_dir  <= pick;
            st        <= ST_IDLE;
          end else begin
            step_cnt <= step_cnt + 1'b1;
            dir_up   <= go_up;
            cur      <= go_up ? rgt : lft;
            st       <= ST_CHK;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/orient_peak_search_chk.sv
module orient_peak_search_chk #(
  parameter int NORI = 16,
  parameter int EW   = 32,
  localparam int IW  = $clog2(NORI)
) (
  input logic                clk,
  input logic                rst,
  input logic                blk_start,
  input logic                blk_first,
  input logic                blk_pad,
  input logic                req_valid,
  input logic [IW-1:0]       req_idx,
  input logic                rsp_valid,
  input logic                busy,
  input logic                res_valid,
  input logic signed [IW:0]  res_dir,
  input logic                res_lowq
);

  // Independent record of which indices were served in the current block.
  logic [NORI-1:0] served;

  always_ff @(posedge clk) begin
    if (rst)                          served <= '0;
    else if (blk_start && !busy)      served <= '0;
    else if (req_valid && rsp_valid)  served[req_idx] <= 1'b1;
  end

  a_r7_no_repeat: assert property (@(posedge clk) disable iff (rst)
    req_valid && rsp_valid |-> !served[req_idx]);

  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    req_valid && !rsp_valid |=> req_valid && $stable(req_idx));

  a_r1_pad_result: assert property (@(posedge clk) disable iff (rst)
    blk_start && blk_pad && !busy |=> res_valid && (res_dir == '1) && !res_lowq && !req_valid);

  a_r2_scan_from_zero: assert property (@(posedge clk) disable iff (rst)
    blk_start && blk_first && !blk_pad && !busy |=> req_valid && (req_idx == '0));

  a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !busy);

  a_r8_lowq_has_dir: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_lowq |-> !res_dir[IW]);

endmodule

bind orient_peak_search orient_peak_search_chk #(.NORI(NORI), .EW(EW)) i_chk (
  .clk(clk), .rst(rst), .blk_start(blk_start), .blk_first(blk_first),
  .blk_pad(blk_pad), .req_valid(req_valid), .req_idx(req_idx),
  .rsp_valid(rsp_valid), .busy(busy), .res_valid(res_valid),
  .res_dir(res_dir), .res_lowq(res_lowq)
);

// File: tb/test_orient_peak_search.sv
`timescale 1ns/1ps
module test_orient_peak_search;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        blk_start = 1'b0, blk_first = 1'b0, blk_pad = 1'b0;
  logic        th_we = 1'b0;
  logic [31:0] th_wdata = '0;
  logic        req_valid;
  logic [3:0]  req_idx;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_energy = '0;
  logic        busy, res_valid, res_lowq;
  logic [4:0]  res_dir;

  int checks = 0, fails = 0;
  int cur_pat = 0, nreq = 0, dup = 0;
  bit [15:0] seen = '0;

  always #2.5 clk = ~clk;

  orient_peak_search i_orient_peak_search (
    .clk(clk), .rst(rst), .blk_start(blk_start), .blk_first(blk_first),
    .blk_pad(blk_pad), .th_we(th_we), .th_wdata(th_wdata),
    .req_valid(req_valid), .req_idx(req_idx), .rsp_valid(rsp_valid),
    .rsp_energy(rsp_energy), .busy(busy), .res_valid(res_valid),
    .res_dir(res_dir), .res_lowq(res_lowq)
  );

  function automatic int cdist(int a, int b);
    int d = (a > b) ? a - b : b - a;
    return (d > 8) ? 16 - d : d;
  endfunction

  function automatic logic [31:0] en(int p, int i);
    int a, b;
    case (p)
      0: return 32'(40_000_000 - 2_000_000 * cdist(i, 5));
      1: return 32'(40_000_000 - 2_000_000 * cdist(i, 7));
      2: return 32'(40_000_000 - 2_000_000 * cdist(i, 15));
      3: return 32'(1000 * i);
      4: begin
        a = 20_000_000 - 1_000_000 * cdist(i, 2);
        b = 50_000_000 - 5_000_000 * cdist(i, 10);
        return 32'((a > b) ? a : b);
      end
      5: return 32'(40_000_000 - 2_000_000 * cdist(i, 0));
      6: return 32'(40_000_000 - 2_000_000 * cdist(i, 2));
      7: return 32'(27_000_001 - 1_000_000 * cdist(i, 3));
      default: return 32'(27_000_000 - 1_000_000 * cdist(i, 3));
    endcase
  endfunction

  // Energy engine model: one-cycle response to each request.
  initial begin
    forever begin
      @(negedge clk);
      if (req_valid && !rsp_valid) begin
        if (seen[req_idx]) dup++;
        seen[req_idx] = 1'b1;
        nreq++;
        rsp_energy = en(cur_pat, int'(req_idx));
        rsp_valid  = 1'b1;
      end else begin
        rsp_valid = 1'b0;
      end
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run_blk(bit f, bit p, int pat, logic [4:0] exp_dir,
                         bit exp_lq, int exp_n, string tag);
    int guard = 0;
    cur_pat = pat; seen = '0; nreq = 0; dup = 0;
    @(negedge clk);
    blk_first = f; blk_pad = p; blk_start = 1'b1;
    @(negedge clk);
    blk_start = 1'b0;
    while (!res_valid && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk(guard < 2000, tag, "result timeout", guard, 0);
    chk(res_dir == exp_dir, tag, "direction", int'(res_dir), int'(exp_dir));
    chk(res_lowq == exp_lq, tag, "low quality flag", int'(res_lowq), int'(exp_lq));
    chk(nreq == exp_n, "R3 R10", "request count", nreq, exp_n);
    chk(dup == 0, "R7", "repeated requests", dup, 0);
    chk(!busy, "R11", "busy at result", int'(busy), 0);
    @(negedge clk);
    chk(!res_valid, "R11", "result pulse length", int'(res_valid), 0);
  endtask

  // {first, pad, pattern[3:0], dir[4:0], lowq, requests[4:0]}
  localparam logic [16:0] TAB [12] = '{
    {1'b1, 1'b0, 4'd0, 5'd5,    1'b0, 5'd16},
    {1'b0, 1'b0, 4'd0, 5'd5,    1'b0, 5'd3 },
    {1'b0, 1'b0, 4'd1, 5'd7,    1'b0, 5'd5 },
    {1'b0, 1'b0, 4'd2, 5'd15,   1'b0, 5'd11},
    {1'b0, 1'b0, 4'd5, 5'd0,    1'b0, 5'd4 },
    {1'b0, 1'b1, 4'd0, 5'h1f,   1'b0, 5'd0 },
    {1'b0, 1'b0, 4'd0, 5'd5,    1'b0, 5'd8 },
    {1'b0, 1'b0, 4'd3, 5'd15,   1'b1, 5'd16},
    {1'b0, 1'b0, 4'd4, 5'd10,   1'b0, 5'd8 },
    {1'b0, 1'b0, 4'd6, 5'd2,    1'b0, 5'd11},
    {1'b0, 1'b0, 4'd4, 5'd10,   1'b0, 5'd11},
    {1'b1, 1'b0, 4'd3, 5'd15,   1'b1, 5'd16}
  };

  function automatic string tag_of(logic [16:0] e);
    if (e[15])                      return "R1";
    if (e[16])                      return "R2";
    if (e[14:11] == 4'd2 || e[14:11] == 4'd5) return "R6";
    if (e[5])                       return "R8";
    return "R5";
  endfunction

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 R10: idle reset state
    chk(!res_valid, "R11", "reset res_valid", int'(res_valid), 0);
    chk(!req_valid, "R10", "reset req_valid", int'(req_valid), 0);
    chk(!busy, "R11", "reset busy", int'(busy), 0);

    // R9 R4: default threshold, one above and exactly equal
    run_blk(1'b1, 1'b0, 7, 5'd3, 1'b0, 16, "R9");
    run_blk(1'b1, 1'b0, 8, 5'd3, 1'b1, 16, "R4");

    // R9: lowered threshold lets the weak ring top qualify, seed 3
    @(negedge clk);
    th_we = 1'b1; th_wdata = 32'd10000;
    @(negedge clk);
    th_we = 1'b0;
    run_blk(1'b0, 1'b0, 3, 5'd15, 1'b0, 15, "R9");
    @(negedge clk);
    th_we = 1'b1; th_wdata = 32'd27_000_000;
    @(negedge clk);
    th_we = 1'b0;

    for (int k = 0; k < 12; k++) begin
      run_blk(TAB[k][16], TAB[k][15], int'(TAB[k][14:11]), TAB[k][10:6],
              TAB[k][5], int'(TAB[k][4:0]), tag_of(TAB[k]));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule